// File: doc/BRIEF.md
# Reseeded LFSR Self-Test Pattern Source

This block is a built-in self-test engine for a purely combinational logic cone. A small table holds seed words and run lengths. When a test starts, the engine takes the entries in address order. For each entry it loads the seed into a Fibonacci LFSR and applies that many consecutive patterns to the circuit under test. It then reloads from the next entry.

The responses of the circuit come back on every pattern cycle. They are compressed into a multiple-input signature register that uses the same feedback polynomial as the generator. This register is cleared once when the test starts and keeps accumulating across all the seeds. When the last pattern has been folded in, a one-cycle completion pulse is raised. The final signature then stays on its output for comparison against a known-good value.

Reseeding gives a test that is much shorter than one long pseudo-random run, while storing only a handful of words. Software fills the tables through a simple write port while the engine is idle.

Top module: `reseed_bist`

## Requirements
- R1: After reset the engine is idle: `done` and `pat_valid` are low and `signature` is zero.
- R2: A write with `wr_en` high while idle stores `wr_seed` and `wr_len` at `wr_addr`. A write while a test is in progress changes no table entry.
- R3: On an accepted `start`, the table entries are used one by one, from address 0 up to address DEPTH-1.
- R4: The first pattern of each sequence equals that entry's seed. Each following pattern is the previous one shifted left by one bit, with the new bit 0 being the XOR of the bits selected by TAPS (default 0xB400, i.e. x^16+x^14+x^13+x^11+1).
- R5: An entry with run length L yields exactly L consecutive cycles with `pat_valid` high. An entry with length 0 yields none.
- R6: Every entry, including a skipped one, costs exactly one load cycle with `pat_valid` low, and `signature` does not change during it.
- R7: An accepted `start` clears the signature to zero. On every cycle with `pat_valid` high, the signature becomes its own LFSR step (same TAPS) XOR `resp`. It is never reset between seeds.
- R8: `done` is high for exactly one cycle, immediately after the last pattern (or the last skipped entry). From then on, `signature` holds its value until the next accepted `start`.
- R9: A `start` pulse while a test is in progress is ignored; the running test proceeds unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test (accepted only while idle) |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | AW | Table entry address |
| wr_seed | input | W | Seed to store |
| wr_len | input | LEN_W | Run length to store |
| pattern | output | W | Pattern applied to the circuit under test |
| pat_valid | output | 1 | High on cycles that apply a pattern |
| resp | input | W | Response of the circuit under test |
| signature | output | W | Signature register contents |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several properties on every cycle. Consecutive patterns must follow the generator recurrence. The signature must stay frozen on any cycle that neither applies a pattern nor accepts a start. An accepted start must zero the signature. `done` must be a single-cycle pulse that never coincides with a pattern.

Some behaviours can only be shown by the bench's scenarios. These are the order in which seeds are taken, the exact count of patterns and load cycles per entry, skipped entries, and the final signature value. The same goes for ignored starts and table writes issued mid-test, which the bench detects by running the test again and comparing the pattern stream.

// File: rtl/reseed_bist.sv
module reseed_bist #(
  parameter int W = 16,
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [W-1:0]     wr_seed,
  input  logic [LEN_W-1:0] wr_len,
  output logic [W-1:0]     pattern,
  output logic             pat_valid,
  input  logic [W-1:0]     resp,
  output logic [W-1:0]     signature,
  output logic             done
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_DONE} state_t;

  state_t            state;
  logic [W-1:0]      seed_mem [DEPTH];
  logic [LEN_W-1:0]  len_mem  [DEPTH];
  logic [AW-1:0]     idx;
  logic [LEN_W-1:0]  cnt;
  logic [W-1:0]      lfsr, misr;
  logic              in_idle, last_idx;

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  assign in_idle   = (state == S_IDLE);
  assign last_idx  = (idx == AW'(DEPTH-1));
  assign pattern   = lfsr;
  assign pat_valid = (state == S_RUN);
  assign done      = (state == S_DONE);
  assign signature = misr;

  always_ff @(posedge clk) begin
    if (wr_en && in_idle) begin
      seed_mem[wr_addr] <= wr_seed;
      len_mem[wr_addr]  <= wr_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      cnt   <= '0;
      lfsr  <= '0;
      misr  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          idx   <= '0;
          misr  <= '0;
          state <= S_LOAD;
        end
        S_LOAD: begin
          lfsr <= seed_mem[idx];
          cnt  <= len_mem[idx];
          if (len_mem[idx] != '0) state <= S_RUN;
          else if (last_idx)      state <= S_DONE;
          else                    idx   <= idx + AW'(1);
        end
        S_RUN: begin
          lfsr <= step(lfsr);
          misr <= step(misr) ^ resp;
          cnt  <= cnt - LEN_W'(1);
          if (cnt == LEN_W'(1)) begin
            if (last_idx) state <= S_DONE;
            else begin
              idx   <= idx + AW'(1);
              state <= S_LOAD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/reseed_bist_chk.sv
module reseed_bist_chk #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         idle,
  input logic         pat_valid,
  input logic [W-1:0] pattern,
  input logic [W-1:0] signature,
  input logic         done
);

  function automatic logic [W-1:0] nxt(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  AST_PATTERN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && $past(pat_valid)) |-> pattern == nxt($past(pattern))); // R4

  AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pat_valid && !(start && idle)) |=> $stable(signature)); // R6

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> signature == '0); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pat_valid); // R8

endmodule

bind reseed_bist reseed_bist_chk #(.W(W), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .idle(in_idle),
  .pat_valid(pat_valid), .pattern(pattern), .signature(signature), .done(done)
);

// File: tb/sim_reseed_bist.sv
`timescale 1ns/1ps
module sim_reseed_bist;
  localparam int W = 16, DEPTH = 8, LEN_W = 16, AW = 3;
  localparam logic [W-1:0] TAPS = 16'hB400;

  logic clk = 0, rst_n = 0, start = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0] wr_seed = '0;
  logic [LEN_W-1:0] wr_len = '0;
  logic [W-1:0] pattern, resp, signature;
  logic pat_valid, done;

  int checks = 0, errors = 0;
  logic [W-1:0] seeds [DEPTH];
  logic [LEN_W-1:0] lens [DEPTH];
  bit exp_v[$];
  logic [W-1:0] exp_p[$];
  logic [W-1:0] exp_sig;
  logic [W-1:0] run_log[$];

  always #4 clk = ~clk;

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  function automatic logic [W-1:0] cut(input logic [W-1:0] p);
    return {p[7:0] ^ p[15:8], (p[15:8] & p[7:0]) | {p[3:0], p[15:12]}};
  endfunction

  assign resp = cut(pattern);

  reseed_bist #(.W(W), .DEPTH(DEPTH), .LEN_W(LEN_W), .TAPS(TAPS)) u0 (
    .clk, .rst_n, .start, .wr_en, .wr_addr, .wr_seed, .wr_len,
    .pattern, .pat_valid, .resp, .signature, .done);

  task automatic chk(input bit ok, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic write_tables();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = AW'(i); wr_seed = seeds[i]; wr_len = lens[i];
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic build_expect();
    logic [W-1:0] s, m;
    exp_v.delete(); exp_p.delete();
    m = '0;
    for (int i = 0; i < DEPTH; i++) begin
      exp_v.push_back(0); exp_p.push_back('0);
      s = seeds[i];
      for (int k = 0; k < int'(lens[i]); k++) begin
        exp_v.push_back(1); exp_p.push_back(s);
        m = step(m) ^ cut(s);
        s = step(s);
      end
    end
    exp_sig = m;
  endtask

  task automatic run_test(input int poke, input bit poke_start, input bit poke_wr);
    logic [W-1:0] held;
    build_expect();
    run_log.delete();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int c = 0; c < exp_v.size(); c++) begin
      if (c > 0) begin
        @(negedge clk);
        start = 0; wr_en = 0;
      end
      chk(pat_valid == exp_v[c], exp_v[c] ? "R5 pat_valid in run" : "R6 load cycle pat_valid",
          W'(pat_valid), W'(exp_v[c]));
      chk(done == 0, "R8 done early", W'(done), '0);
      if (exp_v[c] && pat_valid) begin
        chk(pattern == exp_p[c], "R3 R4 pattern value", pattern, exp_p[c]);
        run_log.push_back(pattern);
      end
      if (c == poke) begin
        if (poke_start) start = 1;            // R9
        if (poke_wr) begin                     // R2
          wr_en = 1; wr_addr = '0; wr_seed = ~seeds[0]; wr_len = 16'd5;
        end
      end
    end
    @(negedge clk);
    start = 0; wr_en = 0;
    chk(done == 1, "R8 done pulse", W'(done), 1);
    chk(signature == exp_sig, "R7 final signature", signature, exp_sig);
    held = signature;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(done == 0, "R8 done single cycle", W'(done), '0);
      chk(signature == held, "R8 signature holds", signature, held);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] first_run[$];
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    chk(done == 0 && pat_valid == 0, "R1 reset outputs", W'({done, pat_valid}), '0);
    chk(signature == '0, "R1 reset signature", signature, '0);
    rst_n = 1;

    // Directed: first and middle entries skipped, last entry a single pattern
    for (int i = 0; i < DEPTH; i++) begin
      seeds[i] = W'(16'h1001 * (i + 1));
      lens[i]  = LEN_W'(i % 3);
    end
    lens[DEPTH-1] = 1;
    write_tables();
    run_test(-1, 0, 0);

    // Directed: every entry skipped, signature stays zero
    for (int i = 0; i < DEPTH; i++) lens[i] = 0;
    write_tables();
    run_test(-1, 0, 0);
    chk(signature == '0, "R5 all skipped signature", signature, '0);

    // Start and table write poked mid-run, then rerun must match
    for (int i = 0; i < DEPTH; i++) begin
      seeds[i] = W'($urandom) | 16'h0001;
      lens[i]  = LEN_W'($urandom_range(1, 9));
    end
    write_tables();
    run_test(4, 1, 1);
    first_run = run_log;
    run_test(-1, 0, 0);
    chk(run_log.size() == first_run.size(), "R2 R9 rerun length", W'(run_log.size()), W'(first_run.size()));
    for (int i = 0; i < run_log.size() && i < first_run.size(); i++)
      chk(run_log[i] == first_run[i], "R2 R9 rerun pattern", run_log[i], first_run[i]);

    // Constrained random tables
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < DEPTH; i++) begin
        seeds[i] = W'($urandom) | 16'h0100;
        lens[i]  = ($urandom_range(0, 3) == 0) ? '0 : LEN_W'($urandom_range(1, 20));
      end
      write_tables();
      run_test(int'($urandom_range(1, 6)), 1, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule